// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block sits between a 32-bit system bus and a PCI host bridge and makes the routing decision for each address. Towards the PCI bus, the top 256 MB of the address space (top nibble 0xF) is cut into 8 MB chunks. An outbound address is forwarded when three things hold: the global forwarding state is on, the address falls in one of the chunks 1 to 30, and the mask bit for that chunk is set. The decoder reports a hit flag and the chunk index.

Two control registers are loaded through a write-only port. One is a per-chunk window mask. The other is a control word whose bits [8:7] drive a two-state machine:

- **FS_BLOCKED** is the reset state. It takes transition **T_ENABLE** to **FS_FORWARD** when the control word is written with bits [8:7] = 2'b01.
- **FS_FORWARD** takes transition **T_DISABLE** back to FS_BLOCKED when the control word is written with any other value in those bits.
- Every other cycle is a **hold**, and the state does not change.

Towards the system side, the block classifies inbound bus-master addresses into system RAM, PCI memory, the CPU local area, or no target. This classification does not depend on the control registers.

Top module: `outbound_window_decoder`

## Requirements
- R1: After reset the state is FS_BLOCKED and the window mask is zero, so `out_hit` is 0 for every address.
- R2: Forwarding is on only after a control write (`cfg_sel`=1) with `cfg_wdata[8:7]` = 2'b01. A control write with 2'b00, 2'b10 or 2'b11 there turns it off, and then no address hits.
- R3: When forwarding is on, an address with bits [31:28] = 0xF hits when its chunk index `addr[27:23]` is in 1..30 and mask bit i is set. `out_chunk` then equals that index.
- R4: Mask bits 0 and 31 never enable a window. Addresses 0xF000_0000–0xF07F_FFFF and 0xFF80_0000–0xFFFF_FFFF never hit.
- R5: Addresses whose bits [31:28] are not 0xF never hit.
- R6: `in_target` is 2'b01 (system RAM) for inbound addresses below 0xF080_0000.
- R7: `in_target` is 2'b10 (PCI memory) for inbound addresses from 0xF080_0000 up to, but not including, 0xFF80_0000.
- R8: `in_target` is 2'b11 (CPU local) for inbound addresses from 0xFFF0_0000 to 0xFFFF_FFFF.
- R9: `in_target` is 2'b00 (no target) for inbound addresses from 0xFF80_0000 to 0xFFEF_FFFF.
- R10: A register write (`cfg_sel`=0 loads the mask) takes effect from the cycle after its clock edge. In the write cycle itself, the decode still uses the old values.
- R11: `out_chunk` is 0 whenever `out_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = window mask, 1 = control word |
| cfg_wdata | input | 32 | Register write data |
| out_addr | input | 32 | Outbound system-bus address |
| out_hit | output | 1 | Address is forwarded to PCI |
| out_chunk | output | 5 | Index of the hit chunk, 0 on a miss |
| in_addr | input | 32 | Inbound bus-master address |
| in_target | output | 2 | Inbound target code |

## Verification
Two functions can fall in the same cycle: a register write, and the decode of an outbound address that the write affects. To provoke this, the bench presents a mask or control write together with an address inside the affected chunk.

It checks the outputs twice. Before the clock edge they must follow the old register values. After the edge they must follow the new ones. Both checks are judged against a behavioural model that applies each write only at the edge.

// File: rtl/owd_pkg.sv
package owd_pkg;

    typedef enum logic {
        FS_BLOCKED = 1'b0,
        FS_FORWARD = 1'b1
    } fwd_state_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_RAM  = 2'b01,
        TGT_PCI  = 2'b10,
        TGT_CPU  = 2'b11
    } tgt_t;

    localparam logic SEL_MASK = 1'b0;
    localparam logic SEL_CTRL = 1'b1;
    localparam logic [1:0] FWD_CODE_ON = 2'b01;

endpackage

// File: rtl/owd_ctrl.sv
module owd_ctrl
    import owd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_CHUNKS = 32,
    parameter int FWD_LSB    = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_sel,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic                  fwd_on,
    output logic [NUM_CHUNKS-1:0] win_mask
);
    // first and last chunk can never be opened
    localparam logic [NUM_CHUNKS-1:0] KEEP = {1'b0, {(NUM_CHUNKS-2){1'b1}}, 1'b0};

    fwd_state_t state_q, state_d;
    logic       ctrl_wr;
    logic [1:0] fwd_field;

    assign ctrl_wr   = cfg_we && (cfg_sel == SEL_CTRL);
    assign fwd_field = cfg_wdata[FWD_LSB+1:FWD_LSB];

    // next state
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            unique case (state_q)
                FS_BLOCKED: if (fwd_field == FWD_CODE_ON) state_d = FS_FORWARD; // T_ENABLE
                FS_FORWARD: if (fwd_field != FWD_CODE_ON) state_d = FS_BLOCKED; // T_DISABLE
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_BLOCKED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        fwd_on = (state_q == FS_FORWARD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            win_mask <= '0;
        else if (cfg_we && (cfg_sel == SEL_MASK))
            win_mask <= cfg_wdata[NUM_CHUNKS-1:0] & KEEP;
    end

    AST_ENABLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && fwd_field == FWD_CODE_ON) |=> fwd_on); // R2
    AST_DISABLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && fwd_field != FWD_CODE_ON) |=> !fwd_on); // R2
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(win_mask) && $stable(fwd_on))); // R10

endmodule

// File: rtl/owd_out_dec.sv
module owd_out_dec #(
    parameter int ADDR_W     = 32,
    parameter int CHUNK_LOG2 = 23,
    parameter int CHUNK_W    = 5,
    parameter int NUM_CHUNKS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fwd_on,
    input  logic [NUM_CHUNKS-1:0] win_mask,
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit,
    output logic [CHUNK_W-1:0]    chunk
);
    logic               in_top;
    logic [CHUNK_W-1:0] idx;
    logic               unused_low;

    assign in_top     = (addr[ADDR_W-1:ADDR_W-4] == 4'hF);
    assign idx        = addr[CHUNK_LOG2+CHUNK_W-1:CHUNK_LOG2];
    assign unused_low = ^addr[CHUNK_LOG2-1:0];

    always_comb begin
        hit   = fwd_on && in_top && win_mask[idx];
        chunk = hit ? idx : '0;
    end

    AST_HIT_NEEDS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> fwd_on); // R2
    AST_HIT_INNER_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (chunk != '0 && chunk != '1)); // R4
    AST_HIT_TOP_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (addr[ADDR_W-1:ADDR_W-4] == 4'hF)); // R5
    AST_MISS_ZERO_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (chunk == '0)); // R11

endmodule

// File: rtl/owd_in_cls.sv
module owd_in_cls
    import owd_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              CHUNK_LOG2 = 23,
    parameter int              NUM_CHUNKS = 32,
    parameter logic [ADDR_W-1:0] CPU_BASE = 32'hFFF0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output tgt_t              tgt
);
    localparam logic [ADDR_W-1:0] WIN_BASE = {4'hF, {(ADDR_W-4){1'b0}}};
    localparam logic [ADDR_W-1:0] PCI_LO   = WIN_BASE + (ADDR_W'(1) << CHUNK_LOG2);
    localparam logic [ADDR_W-1:0] PCI_HI   = WIN_BASE + (ADDR_W'(NUM_CHUNKS-1) << CHUNK_LOG2);

    always_comb begin
        if (addr < PCI_LO)        tgt = TGT_RAM;
        else if (addr < PCI_HI)   tgt = TGT_PCI;
        else if (addr >= CPU_BASE) tgt = TGT_CPU;
        else                      tgt = TGT_NONE;
    end

    AST_LOW_IS_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1:ADDR_W-4] != 4'hF) |-> (tgt == TGT_RAM)); // R6
    AST_CPU_AREA: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1:ADDR_W-12] == 12'hFFF) |-> (tgt == TGT_CPU)); // R8
    AST_PCI_IN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_PCI) |-> (addr[ADDR_W-1:ADDR_W-4] == 4'hF)); // R7

endmodule

// File: rtl/outbound_window_decoder.sv
module outbound_window_decoder
    import owd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CHUNK_LOG2 = 23,
    parameter int FWD_LSB    = 7,
    parameter logic [ADDR_W-1:0] CPU_BASE = 32'hFFF0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] out_addr,
    output logic              out_hit,
    output logic [ADDR_W-5-CHUNK_LOG2:0] out_chunk,
    input  logic [ADDR_W-1:0] in_addr,
    output logic [1:0]        in_target
);
    localparam int CHUNK_W    = ADDR_W - 4 - CHUNK_LOG2;
    localparam int NUM_CHUNKS = 1 << CHUNK_W;

    logic                  fwd_on;
    logic [NUM_CHUNKS-1:0] win_mask;
    tgt_t                  tgt;

    owd_ctrl #(
        .DATA_W(DATA_W), .NUM_CHUNKS(NUM_CHUNKS), .FWD_LSB(FWD_LSB)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .fwd_on(fwd_on), .win_mask(win_mask)
    );

    owd_out_dec #(
        .ADDR_W(ADDR_W), .CHUNK_LOG2(CHUNK_LOG2), .CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .fwd_on(fwd_on), .win_mask(win_mask),
        .addr(out_addr), .hit(out_hit), .chunk(out_chunk)
    );

    owd_in_cls #(
        .ADDR_W(ADDR_W), .CHUNK_LOG2(CHUNK_LOG2), .NUM_CHUNKS(NUM_CHUNKS), .CPU_BASE(CPU_BASE)
    ) u_in (
        .clk(clk), .rst_n(rst_n), .addr(in_addr), .tgt(tgt)
    );

    assign in_target = tgt;

    AST_RESET_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_hit); // R1

endmodule

// File: tb/outbound_window_decoder_tb.sv
`timescale 1ns/1ps
module outbound_window_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] out_addr = '0;
    logic        out_hit;
    logic [4:0]  out_chunk;
    logic [31:0] in_addr = '0;
    logic [1:0]  in_target;

    int errors = 0;
    int checks = 0;

    // reference state
    logic [31:0] m_mask = '0;
    logic [31:0] m_ctrl = '0;

    always #2.5 clk = ~clk;

    outbound_window_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .out_addr(out_addr), .out_hit(out_hit),
        .out_chunk(out_chunk), .in_addr(in_addr), .in_target(in_target)
    );

    function automatic int exp_tgt(input logic [31:0] a);
        if (a < 32'hF080_0000) return 1;
        if (a < 32'hFF80_0000) return 2;
        if (a >= 32'hFFF0_0000) return 3;
        return 0;
    endfunction

    task automatic compare(input string tag);
        int idx;
        bit eh;
        int ec;
        int et;
        idx = int'(out_addr >> 23) % 32;
        eh  = (((m_ctrl >> 7) & 32'd3) == 32'd1) && (out_addr[31:28] == 4'hF)
              && (idx >= 1) && (idx <= 30) && m_mask[idx];
        ec  = eh ? idx : 0;
        et  = exp_tgt(in_addr);
        checks++;
        if (out_hit !== eh || int'(out_chunk) != ec || int'(in_target) != et) begin
            errors++;
            $display("FAIL %s: addr=%h hit=%0b chunk=%0d tgt=%0d, expected hit=%0b chunk=%0d tgt=%0d (in=%h)",
                     tag, out_addr, out_hit, out_chunk, in_target, eh, ec, et, in_addr);
        end
    endtask

    // one cycle: drive after a falling edge, check old view, clock, check new view
    task automatic cyc(input bit we, input bit sel, input logic [31:0] wd,
                       input logic [31:0] oa, input logic [31:0] ia, input string tag);
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd; out_addr = oa; in_addr = ia;
        #1;
        compare(we ? "R10 before edge" : tag);
        @(posedge clk);
        if (we) begin
            if (sel) m_ctrl = wd;
            else     m_mask = wd;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        compare(we ? "R10 after edge" : tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        out_addr = 32'hF100_0000;
        in_addr  = 32'h0000_1000;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        cyc(0, 0, 0, 32'hF100_0000, 32'h1234_0000, "R1 after reset");
        // mask all ones, forwarding still off
        cyc(1, 0, 32'hFFFF_FFFF, 32'hF100_0000, 32'hF080_0000, "R2");
        cyc(0, 0, 0, 32'hF880_0000, 32'hFF7F_FFFF, "R2 blocked");
        // control field values
        cyc(1, 1, 32'h0000_0100, 32'hF100_0000, 0, "R2 field 10");
        cyc(1, 1, 32'h0000_0180, 32'hF100_0000, 0, "R2 field 11");
        cyc(1, 1, 32'hFFFF_FE7F, 32'hF100_0000, 0, "R2 field 00");
        cyc(1, 1, 32'h0000_00FF, 32'hF100_0000, 0, "R2 field 01");
        // sweep all chunks with various masks
        foreach (m_mask[k]) begin end
        for (int p = 0; p < 3; p++) begin
            logic [31:0] mv;
            mv = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'hAAAA_AAAA : 32'h5555_5555;
            cyc(1, 0, mv, 32'hF000_0000, 32'hF07F_FFFF, "R10 mask");
            for (int c = 0; c < 32; c++) begin
                cyc(0, 0, 0, 32'hF000_0000 + (c << 23) + 32'h0004_5678, 32'hF000_0000 + (c << 23),
                    (c == 0 || c == 31) ? "R4 edge chunk" : "R3 chunk sweep");
            end
        end
        cyc(1, 0, 32'hFFFF_FFFF, 0, 0, "R10");
        // edges and outside the top nibble
        cyc(0, 0, 0, 32'hF07F_FFFF, 32'hF07F_FFFF, "R4 below first window R6");
        cyc(0, 0, 0, 32'hF080_0000, 32'hF080_0000, "R3 first window R7");
        cyc(0, 0, 0, 32'hFF7F_FFFF, 32'hFF7F_FFFF, "R3 last window R7");
        cyc(0, 0, 0, 32'hFF80_0000, 32'hFF80_0000, "R4 chunk 31 R9");
        cyc(0, 0, 0, 32'hE880_0000, 32'hFFEF_FFFF, "R5 outside R9");
        cyc(0, 0, 0, 32'h7080_0000, 32'hFFF0_0000, "R5 outside R8");
        cyc(0, 0, 0, 32'h0000_0000, 32'hFFFF_FFFF, "R11 R8");
        // same-cycle write and decode
        cyc(1, 0, 32'h0000_0004, 32'hF100_0000, 32'h0, "R10");
        cyc(1, 0, 32'h0000_0002, 32'hF100_0000, 32'h0, "R10");
        cyc(1, 1, 32'h0, 32'hF080_0000, 32'h0, "R10");
        cyc(1, 1, 32'h80, 32'hF080_0000, 32'h0, "R10");
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r1, r2, r3;
            r1 = $urandom; r2 = $urandom; r3 = $urandom;
            if (r2[0]) r2[31:28] = 4'hF;
            if (r3[1]) r3[31:24] = 8'hFF;
            cyc((r1[3:0] == 0), r1[4], (r1[5] ? ($urandom | 32'h80) & ~32'h100 : $urandom),
                r2, r3, "R3 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule